// File: doc/BRIEF.md
# RISC Pipeline Instruction-Decode Stage

This block is the decode stage of a 32-bit, five-stage RISC pipeline. It takes the fetched 32-bit instruction word and a 2-bit class code. It pulls the two source register numbers out of fixed bit fields and reads both operands from a 32 x 32-bit register file. It widens the 16-bit immediate to 32 bits with sign extension. It also picks the destination register number that matches the instruction class. The outputs go straight to the execute stage.

The write-back stage writes into the register file through a port with an address, data and an enable. The file captures data on the falling clock edge. Its reads are combinational, so a value written in a cycle appears on a read port in the second half of that same cycle, with no bypass path. Register 0 is hard-wired to zero.

Top module: `decode_stage`

## Requirements
- R1: `opnd_a` shows the register selected by instruction bits 25:21 and `opnd_b` the register selected by bits 20:16. Both follow changes of `instr` combinationally, with no clock edge.
- R2: With `wb_en` high and a nonzero `wb_addr`, the register at `wb_addr` takes `wb_data` on the falling clock edge. A read port shows the new value from that edge on, within the same cycle, and shows the old value before it.
- R3: While `wb_en` is low, no register changes, whatever `wb_addr` and `wb_data` carry.
- R4: Register 0 always reads as zero on both ports, and a write addressed to it has no effect.
- R5: A write changes at most one register. Registers whose numbers differ from `wb_addr` keep their contents.
- R6: `imm_ext` holds instruction bits 15:0 in its low 16 bits, and copies of instruction bit 15 in bits 31:16.
- R7: `dest_reg` follows `iclass`. Code 00 gives instruction bits 15:11. Code 01 gives bits 20:16. Code 10 gives register 31. Code 11 gives bits 20:16.
- R8: When `rst` is high at a falling clock edge, every register is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register file updates on its falling edge |
| rst | input | 1 | Synchronous active-high reset of the register file |
| instr | input | 32 | Instruction word being decoded |
| iclass | input | 2 | Instruction class: 00 R-type, 01 I-type, 10 J-type, 11 unused |
| wb_en | input | 1 | Write-back enable |
| wb_addr | input | 5 | Write-back register number |
| wb_data | input | 32 | Write-back data |
| opnd_a | output | 32 | Contents of the first source register |
| opnd_b | output | 32 | Contents of the second source register |
| imm_ext | output | 32 | Sign-extended immediate |
| dest_reg | output | 5 | Destination register number |

## Verification
Each of the 31 writable registers is first loaded with a distinct value built from its own index, so a wrong read selection or a write to the wrong register shows up as a mismatch. A table of instruction words then uses all four class codes. The words include equal source fields, the top and bottom register numbers, and immediates with bit 15 clear, bit 15 set, all ones and all zeros. This separates a port swap, a wrong field boundary and a zero-fill extension from correct behaviour. Directed cases probe a read port before and after the falling edge of a write cycle, a write to register 0, a write with the enable low, the neighbours of a written register, and a reset applied after the registers are loaded.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RIDX = $clog2(NREG);
  localparam int IMMW = 16;

  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;
  localparam int IMM_LSB = 0;

  typedef enum logic [1:0] {
    CLS_R   = 2'b00,
    CLS_I   = 2'b01,
    CLS_J   = 2'b10,
    CLS_RSV = 2'b11
  } iclass_e;

  localparam logic [RIDX-1:0] LINK_REG = RIDX'(NREG - 1);

  function automatic logic [RIDX-1:0] fld_rs(input logic [XLEN-1:0] w);
    return w[RS_LSB +: RIDX];
  endfunction

  function automatic logic [RIDX-1:0] fld_rt(input logic [XLEN-1:0] w);
    return w[RT_LSB +: RIDX];
  endfunction

  function automatic logic [RIDX-1:0] fld_rd(input logic [XLEN-1:0] w);
    return w[RD_LSB +: RIDX];
  endfunction

  function automatic logic [IMMW-1:0] fld_imm(input logic [XLEN-1:0] w);
    return w[IMM_LSB +: IMMW];
  endfunction

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] v);
    return {{(XLEN-IMMW){v[IMMW-1]}}, v};
  endfunction
endpackage

// File: rtl/dec_regfile.sv
module dec_regfile
  import dec_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NREG,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  logic [N-1:0]        wr_strobe;
  logic [N-1:0][W-1:0] bank;

  always_comb begin
    wr_strobe     = '0;
    wr_strobe[wa] = we;
    wr_strobe[0]  = 1'b0;
  end

  assign bank[0] = '0;

  generate
    for (genvar g = 1; g < N; g++) begin : g_reg
      logic [W-1:0] q;
      always_ff @(negedge clk) begin
        if (rst)               q <= '0;
        else if (wr_strobe[g]) q <= wd;
      end
      assign bank[g] = q;
    end
  endgenerate

  assign rd_a = bank[ra_a];
  assign rd_b = bank[ra_b];

  // R5
  wr_onehot_chk: assert property (@(negedge clk) disable iff (rst)
    $onehot0(wr_strobe));

  // R2
  wr_lands_chk: assert property (@(negedge clk) disable iff (rst)
    (we && wa != '0) |=> (bank[$past(wa)] == $past(wd)));

  // R3
  idle_hold_chk: assert property (@(negedge clk) disable iff (rst)
    !we |=> (bank == $past(bank)));

  // R4
  zero_read_a_chk: assert property (@(posedge clk) disable iff (rst)
    (ra_a == '0) |-> (rd_a == '0));

  // R4
  zero_read_b_chk: assert property (@(posedge clk) disable iff (rst)
    (ra_b == '0) |-> (rd_b == '0));
endmodule

// File: rtl/dec_immext.sv
module dec_immext
  import dec_pkg::*;
#(
  parameter int IW = IMMW,
  parameter int W  = XLEN
) (
  input  logic [IW-1:0] imm,
  output logic [W-1:0]  ext
);
  logic sign_bit;
  assign sign_bit = imm[IW-1];
  assign ext      = {{(W-IW){sign_bit}}, imm};
endmodule

// File: rtl/dec_dstsel.sv
module dec_dstsel
  import dec_pkg::*;
#(
  parameter int AW = RIDX
) (
  input  logic [1:0]    cls,
  input  logic [AW-1:0] rt_num,
  input  logic [AW-1:0] rd_num,
  output logic [AW-1:0] dst
);
  iclass_e cls_e;
  assign cls_e = iclass_e'(cls);

  always_comb begin
    unique case (cls_e)
      CLS_R:   dst = rd_num;
      CLS_J:   dst = {AW{1'b1}};
      CLS_I:   dst = rt_num;
      default: dst = rt_num;
    endcase
  end
endmodule

// File: rtl/decode_stage.sv
module decode_stage
  import dec_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] instr,
  input  logic [1:0]      iclass,
  input  logic            wb_en,
  input  logic [RIDX-1:0] wb_addr,
  input  logic [XLEN-1:0] wb_data,
  output logic [XLEN-1:0] opnd_a,
  output logic [XLEN-1:0] opnd_b,
  output logic [XLEN-1:0] imm_ext,
  output logic [RIDX-1:0] dest_reg
);
  logic [RIDX-1:0] src_a_num;
  logic [RIDX-1:0] src_b_num;
  logic [RIDX-1:0] rd_num;
  logic [IMMW-1:0] imm_raw;

  assign src_a_num = fld_rs(instr);
  assign src_b_num = fld_rt(instr);
  assign rd_num    = fld_rd(instr);
  assign imm_raw   = fld_imm(instr);

  dec_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .we   (wb_en),
    .wa   (wb_addr),
    .wd   (wb_data),
    .ra_a (src_a_num),
    .ra_b (src_b_num),
    .rd_a (opnd_a),
    .rd_b (opnd_b)
  );

  dec_immext #(.IW(IMMW), .W(XLEN)) u_ext (
    .imm (imm_raw),
    .ext (imm_ext)
  );

  dec_dstsel #(.AW(RIDX)) u_dst (
    .cls    (iclass),
    .rt_num (src_b_num),
    .rd_num (rd_num),
    .dst    (dest_reg)
  );

  // R6
  imm_low_chk: assert property (@(posedge clk) disable iff (rst)
    imm_ext[IMMW-1:0] == instr[IMMW-1:0]);

  // R6
  imm_high_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(imm_ext[XLEN-1:IMMW]) == (instr[IMMW-1] ? (XLEN-IMMW) : 0));

  // R7
  link_dst_chk: assert property (@(posedge clk) disable iff (rst)
    (iclass == 2'b10) |-> (dest_reg == LINK_REG));

  // R7
  rtype_dst_chk: assert property (@(posedge clk) disable iff (rst)
    (iclass == 2'b00) |-> (dest_reg == instr[15:11]));

  // R7
  itype_dst_chk: assert property (@(posedge clk) disable iff (rst)
    (iclass[0]) |-> (dest_reg == instr[20:16]));
endmodule

// File: tb/decode_stage_test.sv
`timescale 1ns/1ps
module decode_stage_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [1:0]  iclass = '0;
  logic        wb_en = 1'b0;
  logic [4:0]  wb_addr = '0;
  logic [31:0] wb_data = '0;
  logic [31:0] opnd_a, opnd_b, imm_ext;
  logic [4:0]  dest_reg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  decode_stage uut (
    .clk(clk), .rst(rst), .instr(instr), .iclass(iclass),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_ext(imm_ext), .dest_reg(dest_reg)
  );

  // {rs, rt, imm16, class, expected destination}
  localparam logic [32:0] VEC [8] = '{
    {5'd3,  5'd7,  16'h6000, 2'b00, 5'd12},
    {5'd31, 5'd0,  16'h8001, 2'b01, 5'd0},
    {5'd0,  5'd31, 16'hFFFF, 2'b10, 5'd31},
    {5'd17, 5'd5,  16'h7FFF, 2'b11, 5'd5},
    {5'd9,  5'd9,  16'h0800, 2'b00, 5'd1},
    {5'd30, 5'd1,  16'h8000, 2'b01, 5'd1},
    {5'd2,  5'd4,  16'h0000, 2'b10, 5'd31},
    {5'd25, 5'd26, 16'h1234, 2'b00, 5'd2}
  };

  function automatic logic [31:0] pat(input int i);
    logic [7:0] b;
    b = 8'(i);
    return (i == 0) ? 32'h0 : {b, ~b, 8'hC3, b ^ 8'h5A};
  endfunction

  function automatic logic [31:0] mk(input logic [4:0] rs, input logic [4:0] rt,
                                     input logic [15:0] imm);
    return {6'h2A, rs, rt, imm};
  endfunction

  function automatic logic [31:0] widen(input logic [15:0] v);
    return 32'($signed(v));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h, expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic en);
    @(posedge clk); #0.5;
    wb_en = en; wb_addr = 5'(a); wb_data = d;
    @(negedge clk); #0.5;
    wb_en = 1'b0;
  endtask

  task automatic rd2(input int a, input int b);
    instr = mk(5'(a), 5'(b), 16'h0);
    #0.5;
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5;
    // R8: reset state
    rd2(5, 31);
    check("R8 reset a", opnd_a, 32'h0);
    check("R8 reset b", opnd_b, 32'h0);
    rst = 1'b0;

    for (int i = 1; i < 32; i++) wr(i, pat(i), 1'b1);

    // R2: same-cycle readback across the falling edge
    @(posedge clk); #0.5;
    instr = mk(5'd6, 5'd0, 16'h0);
    wb_en = 1'b1; wb_addr = 5'd6; wb_data = 32'hDEAD_0006;
    #0.5;
    check("R2 old before fall", opnd_a, pat(6));
    @(negedge clk); #0.5;
    check("R2 new after fall", opnd_a, 32'hDEAD_0006);
    wb_en = 1'b0;
    wr(6, pat(6), 1'b1);

    // R4: write to register 0 ignored
    wr(0, 32'hFFFF_FFFF, 1'b1);
    rd2(0, 0);
    check("R4 zero a", opnd_a, 32'h0);
    check("R4 zero b", opnd_b, 32'h0);

    // R3: disabled write leaves the register intact
    wr(10, 32'h1234_5678, 1'b0);
    rd2(10, 11);
    check("R3 held", opnd_a, pat(10));

    // R5: only the addressed register changes
    wr(20, 32'hCAFE_0020, 1'b1);
    rd2(19, 21);
    check("R5 lower neighbour", opnd_a, pat(19));
    check("R5 upper neighbour", opnd_b, pat(21));
    rd2(20, 0);
    check("R5 target", opnd_a, 32'hCAFE_0020);
    wr(20, pat(20), 1'b1);

    // R1 R6 R7: vector table
    for (int v = 0; v < 8; v++) begin
      logic [4:0]  rs, rt, dexp;
      logic [15:0] imm;
      {rs, rt, imm, iclass, dexp} = VEC[v];
      instr = mk(rs, rt, imm);
      #0.5;
      check("R1 operand a", opnd_a, pat(int'(rs)));
      check("R1 operand b", opnd_b, pat(int'(rt)));
      check("R6 immediate", imm_ext, widen(imm));
      check("R7 destination", 32'(dest_reg), 32'(dexp));
      @(posedge clk); #0.5;
    end

    // R8: reset after load clears everything
    @(posedge clk); #0.5;
    rst = 1'b1;
    @(negedge clk); #0.5;
    rst = 1'b0;
    rd2(1, 31);
    check("R8 cleared r1", opnd_a, 32'h0);
    check("R8 cleared r31", opnd_b, 32'h0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule